// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block decides when an SDRAM controller must issue REFRESH commands. An interval timer counts a base number of clocks, which is shortened by a 2-bit temperature range code. Each time the interval ends, one more refresh is owed. The owed refreshes are offered to the command arbiter as a request. Each grant retires one of them.

A busy arbiter may leave refreshes owed for a while. The owed count never exceeds eight. When it reaches eight, an urgent flag tells the arbiter to stop postponing. Two refreshes are never requested in adjacent cycles.

When the clock is slow, a mode flag makes the block ask for a PRECHARGE ALL after every granted refresh. The arbiter acknowledges that request with the same grant input.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, ref_req, pall_req and ref_urgent are low and no refresh is owed. The interval timer is loaded from the temperature code present during reset.
- R2: The interval length is BASE_INTERVAL shifted right by temp_code. Code 0 gives the full interval, and codes 1, 2 and 3 give one half, one quarter and one eighth of it. Each expiry adds one owed refresh, so the first ref_req rises exactly interval+1 cycles after reset is released.
- R3: ref_req is asserted while a refresh is owed and no other request is in progress. It stays high until ref_grant is seen.
- R4: A grant seen while ref_req is high retires one owed refresh. A grant seen while neither request is high has no effect.
- R5: After a granted refresh, ref_req is low for at least one cycle. If more refreshes are owed and slow mode is off, ref_req rises again two cycles after the grant.
- R6: The owed count saturates at MAX_OWED (8). Further expiries while saturated are dropped, and a full drain issues exactly eight refreshes.
- R7: ref_urgent is high exactly while the owed count equals MAX_OWED. It falls on the cycle after the first grant that lowers the count.
- R8: With slow_clk_mode high at the moment a refresh is granted, pall_req is high on the next cycle and is held until ref_grant is seen. ref_req and pall_req are never high together.
- R9: With slow_clk_mode low at the grant, no pall_req follows the refresh.
- R10: A change of temp_code takes effect only when the current interval ends, and the owed count is kept across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_code | input | 2 | Temperature range code; 0 is coolest, 3 is hottest |
| ref_grant | input | 1 | Arbiter acceptance of the pending request (refresh or precharge-all) |
| slow_clk_mode | input | 1 | High when the clock period exceeds the slow-clock limit |
| ref_req | output | 1 | Refresh request |
| pall_req | output | 1 | PRECHARGE ALL request following a refresh |
| ref_urgent | output | 1 | Owed count is at its limit |

## Verification
A wrong owed count shows up at the ports in two ways. Each case is caught within one drain, or within one interval.

- A count that is too high shows up as extra refresh grants during a drain, or as ref_urgent rising one interval too early.
- A count that is too low, or one that wraps under a stray grant, shifts the first ref_req edge away from interval+1 cycles.

A wrong timer reload shows up as the eighth expiry, which is flagged by ref_urgent, landing on the wrong cycle. A sequencer fault shows up within one or two cycles of a grant, as a missing gap or a missing or extra pall_req.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REF  = 2'd1,
    SEQ_PALL = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_t;

  localparam int unsigned TEMP_CODES = 4;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int unsigned BASE_INTERVAL = 1950
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] temp_code,
  output logic       tick
);
  localparam int unsigned TW = $clog2(BASE_INTERVAL + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] reload [refresh_pkg::TEMP_CODES];

  for (genvar g = 0; g < refresh_pkg::TEMP_CODES; g++) begin : g_reload
    assign reload[g] = TW'((BASE_INTERVAL >> g) - 1);
  end

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || tick) begin
      cnt <= reload[temp_code];
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr #(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] owed,
  output logic          pending,
  output logic          urgent
);
  localparam int unsigned OW1 = OW + 1;
  localparam logic [OW:0] MAXV = OW1'(MAX_OWED);

  logic [OW:0]   sum;
  logic [OW-1:0] owed_nxt;

  always_comb begin
    sum = {1'b0, owed} + OW1'(inc) - OW1'(dec && (owed != '0));
    if (sum > MAXV) begin
      owed_nxt = MAXV[OW-1:0];
    end else begin
      owed_nxt = sum[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed   <= '0;
      urgent <= 1'b0;
    end else begin
      owed   <= owed_nxt;
      urgent <= ({1'b0, owed_nxt} == MAXV);
    end
  end

  assign pending = (owed != '0);
endmodule

// File: rtl/refresh_req_seq.sv
module refresh_req_seq
  import refresh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic grant,
  input  logic slow_mode,
  output logic ref_req,
  output logic pall_req,
  output logic retire
);
  seq_state_t st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      SEQ_IDLE: nxt = pending ? SEQ_REF : SEQ_IDLE;
      SEQ_REF:  if (grant) nxt = slow_mode ? SEQ_PALL : SEQ_GAP;
      SEQ_PALL: if (grant) nxt = SEQ_GAP;
      SEQ_GAP:  nxt = pending ? SEQ_REF : SEQ_IDLE;
      default:  nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      ref_req  <= 1'b0;
      pall_req <= 1'b0;
    end else begin
      st       <= nxt;
      ref_req  <= (nxt == SEQ_REF);
      pall_req <= (nxt == SEQ_PALL);
    end
  end

  assign retire = ref_req && grant;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned BASE_INTERVAL = 1950,
  parameter int unsigned MAX_OWED      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] temp_code,
  input  logic       ref_grant,
  input  logic       slow_clk_mode,
  output logic       ref_req,
  output logic       pall_req,
  output logic       ref_urgent
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);

  logic          tick;
  logic          retire;
  logic          pending;
  logic [OW-1:0] owed_cnt;

  refresh_interval_timer #(.BASE_INTERVAL(BASE_INTERVAL)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .temp_code (temp_code),
    .tick      (tick)
  );

  refresh_debt_ctr #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk     (clk),
    .rst     (rst),
    .inc     (tick),
    .dec     (retire),
    .owed    (owed_cnt),
    .pending (pending),
    .urgent  (ref_urgent)
  );

  refresh_req_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .pending   (pending),
    .grant     (ref_grant),
    .slow_mode (slow_clk_mode),
    .ref_req   (ref_req),
    .pall_req  (pall_req),
    .retire    (retire)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          ref_grant,
  input logic          slow_clk_mode,
  input logic          ref_req,
  input logic          pall_req,
  input logic          ref_urgent,
  input logic [OW-1:0] owed
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    32'(owed) <= MAX_OWED); // R6
  AST_URGENT_MATCH: assert property (@(posedge clk) disable iff (rst)
    ref_urgent == (32'(owed) == MAX_OWED)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    ref_req && !ref_grant |=> ref_req); // R3
  AST_NOP_GAP: assert property (@(posedge clk) disable iff (rst)
    ref_req && ref_grant |=> !ref_req); // R5
  AST_PALL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ref_req && ref_grant && slow_clk_mode |=> pall_req); // R8
  AST_PALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    pall_req && !ref_grant |=> pall_req); // R8
  AST_NO_PALL_FAST: assert property (@(posedge clk) disable iff (rst)
    ref_req && ref_grant && !slow_clk_mode |=> !pall_req); // R9
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ref_req && pall_req)); // R8
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_OWED(MAX_OWED)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ref_grant     (ref_grant),
  .slow_clk_mode (slow_clk_mode),
  .ref_req       (ref_req),
  .pall_req      (pall_req),
  .ref_urgent    (ref_urgent),
  .owed          (owed_cnt)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int unsigned BASE = 64;
  localparam int NV = 6;
  localparam logic [1:0] V_CODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0};
  localparam bit         V_SLOW [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int         V_EXP  [NV] = '{65, 33, 17, 9, 9, 65};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] temp_code = 2'd0;
  logic ref_grant = 1'b0;
  logic slow_clk_mode = 1'b0;
  logic ref_req, pall_req, ref_urgent;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  refresh_sched #(.BASE_INTERVAL(BASE), .MAX_OWED(8)) u_dut (
    .clk(clk), .rst(rst), .temp_code(temp_code), .ref_grant(ref_grant),
    .slow_clk_mode(slow_clk_mode), .ref_req(ref_req), .pall_req(pall_req),
    .ref_urgent(ref_urgent)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code, input bit slow);
    @(negedge clk);
    rst = 1'b1; temp_code = code; slow_clk_mode = slow; ref_grant = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!ref_req && n < 2000) begin
      step(1);
      n++;
    end
  endtask

  task automatic grant_once();
    ref_grant = 1'b1;
    step(1);
    ref_grant = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int grants;
    // R1 reset state
    do_reset(2'd0, 1'b0);
    check(!ref_req && !pall_req && !ref_urgent, "R1", {ref_req, pall_req, ref_urgent}, 0);

    // Vector walk: R2 interval per code, R8/R9 follow-up
    for (int i = 0; i < NV; i++) begin
      do_reset(V_CODE[i], V_SLOW[i]);
      wait_req(n);
      check(n == V_EXP[i], "R2", n, V_EXP[i]);
      grant_once();
      check(!ref_req, "R5", ref_req, 0);
      check(pall_req == V_SLOW[i], V_SLOW[i] ? "R8" : "R9", pall_req, V_SLOW[i]);
      if (V_SLOW[i]) begin
        step(3);
        check(pall_req && !ref_req, "R8", pall_req, 1);
        grant_once();
        check(!pall_req && !ref_req, "R8", {pall_req, ref_req}, 0);
      end
    end

    // R4 grant without request is ignored
    do_reset(2'd2, 1'b0);
    ref_grant = 1'b1;
    step(10);
    ref_grant = 1'b0;
    check(!ref_req, "R4", ref_req, 0);
    n = 10;
    while (!ref_req && n < 2000) begin step(1); n++; end
    check(n == 17, "R4", n, 17);

    // R7 urgent rises on the eighth expiry
    do_reset(2'd0, 1'b0);
    step(511);
    check(!ref_urgent, "R7", ref_urgent, 0);
    step(1);
    check(ref_urgent, "R7", ref_urgent, 1);

    // R6 saturation: ninth expiry dropped, drain gives exactly eight
    step(66);
    check(ref_urgent && ref_req, "R6", ref_urgent, 1);
    grant_once();
    check(!ref_urgent, "R7", ref_urgent, 0);
    check(!ref_req, "R5", ref_req, 0);
    step(1);
    check(ref_req, "R5", ref_req, 1);
    grants = 1;
    for (int c = 0; c < 40; c++) begin
      ref_grant = ref_req;
      if (ref_req) grants++;
      step(1);
    end
    ref_grant = 1'b0;
    check(grants == 8, "R6", grants, 8);

    // R10 code change lands at the interval boundary; owed count kept
    do_reset(2'd0, 1'b0);
    step(10);
    temp_code = 2'd3;
    step(109);
    check(!ref_urgent, "R10", ref_urgent, 0);
    step(1);
    check(ref_urgent, "R10", ref_urgent, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule